// File: doc/BRIEF.md
# Port-mapped card register interface

This block is the slave side of an 8-bit parallel I/O expansion bus for a telephone voice card. It watches the low ten address bits, the active-low address-enable line and the active-low I/O read and write strobes. It matches a window of eight consecutive ports against a value set on switches, and from that match it produces a card select and one read strobe and one write strobe per register. While the host reads inside the window, the block puts the selected register on the outbound data lines and raises the enable of the external tri-state buffer.

Behind the window the block holds three things. The first is a write-only control byte that drives the off-hook relay, the tape motor and the microphone path. The second is a sample register for the output converter. The third is a sample-ready flag that the input converter's end-of-conversion signal sets. The flag lets software pace its sample reads and writes to the converter rate, and any access to the sample port clears it. A read-only status byte combines the line-status inputs with the flag.

All bus inputs are treated as synchronous to `clk`. The decode and the read path are combinational. Register updates and the flag take effect at the rising clock edge during which the matching strobe is low.

Top module: `pbus_card_regs`

## Requirements
- R1: `card_sel_n` is low exactly when {`bus_aen_n`, `bus_addr[9:3]`} equals `win_sw` and at least one of `bus_ior_n`, `bus_iow_n` is low. With `win_sw` = 8'h4F the window is ports 0x278 to 0x27F, and with 8'h7F it is 0x3F8 to 0x3FF.
- R2: `rd_stb_n[k]` is low exactly when `card_sel_n` and `bus_ior_n` are low and `bus_addr[2:0]` equals k. `wr_stb_n[k]` is low exactly when `card_sel_n` and `bus_iow_n` are low and `bus_addr[2:0]` equals k.
- R3: `bus_doe` is high only while `card_sel_n` and `bus_ior_n` are both low. Otherwise `bus_dout` is 8'h00.
- R4: A read at offset 0 returns `adc_data`. A read at offset 6 returns {4'h0, `dtmf_code`}. Reads at offsets 1 to 5 return 8'hFF.
- R5: A read at offset 7 returns status: bit 0 `line_hook`, bit 1 `line_ring`, bit 2 `line_voice`, bit 3 `dtmf_det`, bit 4 the sample-ready flag, and bits 7..5 zero.
- R6: A write at offset 7 loads `off_hook` from data bit 0, `tape_on` from bit 1 and `mic_on` from bit 2. Bits 7..3 are discarded.
- R7: A write at offset 0 loads `dac_data` with the full data byte.
- R8: Writes at offsets 1 to 6 change neither the control outputs nor `dac_data`.
- R9: A rising edge of `adc_eoc` (high now, low at the previous clock edge) sets the sample-ready flag at that clock edge. A level held high sets it only once.
- R10: A read or a write at offset 0 clears the sample-ready flag at the clock edge during which its strobe is low. A read of status does not clear it.
- R11: When a rising edge of `adc_eoc` and a clearing access fall on the same clock edge, the flag ends up set.
- R12: Reset (`rst_n` low) clears the control outputs, `dac_data` and the sample-ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 10 | Low address bits of the bus |
| bus_aen_n | input | 1 | Address enable, low for a valid port cycle |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data toward the bus buffer |
| bus_doe | output | 1 | Enable for the outbound tri-state buffer |
| win_sw | input | 8 | Switch value {aen, A9..A3} to match |
| card_sel_n | output | 1 | Card select, active low |
| rd_stb_n | output | 8 | Per-offset read strobes, active low |
| wr_stb_n | output | 8 | Per-offset write strobes, active low |
| adc_data | input | 8 | Input converter sample |
| adc_eoc | input | 1 | Input converter end-of-conversion |
| dtmf_code | input | 4 | Decoded tone digit |
| dtmf_det | input | 1 | Tone present |
| line_hook | input | 1 | Hook status from the line |
| line_ring | input | 1 | Ring detect |
| line_voice | input | 1 | Voice activity detect |
| dac_data | output | 8 | Output converter sample register |
| off_hook | output | 1 | Control: take the line off hook |
| tape_on | output | 1 | Control: run the tape recorder |
| mic_on | output | 1 | Control: enable the microphone |

## Verification
The assertions assume that every bus input changes only between clock edges and holds steady across each rising edge. They also assume that the read and write strobes are never low together, and that `adc_eoc` comes from the same clock domain. The stimulus keeps to these rules by changing all inputs only on the falling edge of the clock, by releasing one strobe before it asserts the other, and by driving the end-of-conversion line as a clean level from the same process.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   // status byte layout; software decodes these positions
   localparam int ST_HOOK  = 0;
   localparam int ST_RING  = 1;
   localparam int ST_VOICE = 2;
   localparam int ST_TONE  = 3;
   localparam int ST_READY = 4;
   localparam int ST_USED  = 5;

   // control byte layout
   typedef struct packed {
      logic mic_on;
      logic tape_on;
      logic off_hook;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pbus_win_decode.sv
module pbus_win_decode #(
   parameter int ADDR_W = 10,
   parameter int OFF_W  = 3,
   localparam int NREG  = 1 << OFF_W,
   localparam int SW_W  = ADDR_W - OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              aen_n,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic [SW_W-1:0]   win_sw,
   output logic              card_sel_n,
   output logic [NREG-1:0]   rd_stb_n,
   output logic [NREG-1:0]   wr_stb_n
);

   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("pbus_win_decode: ADDR_W must exceed OFF_W");
   end
   if (OFF_W < 1 || OFF_W > 6) begin : g_bad_off
      $error("pbus_win_decode: OFF_W out of range");
   end

   logic              hit;
   logic              any_stb;
   logic [OFF_W-1:0]  off;

   assign any_stb    = ~ior_n | ~iow_n;
   assign hit        = ({aen_n, addr[ADDR_W-1:OFF_W]} == win_sw);
   assign card_sel_n = ~(hit & any_stb);
   assign off        = addr[OFF_W-1:0];

   for (genvar k = 0; k < NREG; k++) begin : g_stb
      assign rd_stb_n[k] = ~(~card_sel_n & ~ior_n & (off == OFF_W'(k)));
      assign wr_stb_n[k] = ~(~card_sel_n & ~iow_n & (off == OFF_W'(k)));
   end

   // R1: select only appears during a strobe
   p_sel_needs_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !card_sel_n |-> (!ior_n || !iow_n));

   // R2: a read strobe implies select and an I/O read
   p_rd_stb_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_n != '1) |-> (!card_sel_n && !ior_n));

   // R2: at most one write strobe at a time
   p_wr_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~wr_stb_n));

endmodule

// File: rtl/pbus_ctl_regs.sv
module pbus_ctl_regs
   import pbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              dac_we,
   input  logic [DATA_W-1:0] din,
   output ctl_t              ctl_q,
   output logic [DATA_W-1:0] dac_q
);

   if (DATA_W < CTL_W) begin : g_bad_w
      $error("pbus_ctl_regs: DATA_W too narrow for control byte");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         dac_q <= '0;
      end else begin
         if (ctl_we) ctl_q <= ctl_t'(din[CTL_W-1:0]);
         if (dac_we) dac_q <= din;
      end
   end

   // R6: control loads the low data bits
   p_ctl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (ctl_q == $past(din[CTL_W-1:0])));

   // R7: sample register loads the full byte
   p_dac_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dac_we |=> (dac_q == $past(din)));

endmodule

// File: rtl/pbus_ready_flag.sv
module pbus_ready_flag #(
   parameter bit EDGE_DET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc,
   input  logic clr,
   output logic ready
);

   logic set_ev;

   if (EDGE_DET) begin : g_edge
      logic eoc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) eoc_q <= 1'b0;
         else        eoc_q <= eoc;
      end
      assign set_ev = eoc & ~eoc_q;

      // R9: rising end-of-conversion sets the flag (R11: even with a clear)
      p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(eoc) |=> ready);
      // R10: a clear with no new edge empties the flag
      p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !$rose(eoc)) |=> !ready);
   end else begin : g_level
      assign set_ev = eoc;

      p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
         eoc |=> ready);
      p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !eoc) |=> !ready);
   end

   // set outranks clear so a sample is never silently dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ready <= 1'b0;
      else if (set_ev) ready <= 1'b1;
      else if (clr)    ready <= 1'b0;
   end

endmodule

// File: rtl/pbus_rd_mux.sv
module pbus_rd_mux #(
   parameter int              DATA_W     = 8,
   parameter int              OFF_W      = 3,
   parameter int              TONE_W     = 4,
   parameter int              SAMPLE_OFS = 0,
   parameter int              TONE_OFS   = 6,
   parameter int              STAT_OFS   = 7,
   parameter logic [DATA_W-1:0] FILL     = '1,
   localparam int             NREG       = 1 << OFF_W
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] sample,
   input  logic [TONE_W-1:0] tone,
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] rdata
);

   if (TONE_W > DATA_W) begin : g_bad_tone
      $error("pbus_rd_mux: TONE_W wider than DATA_W");
   end

   logic [DATA_W-1:0] src [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_src
      if (k == SAMPLE_OFS) begin : g_sample
         assign src[k] = sample;
      end else if (k == TONE_OFS) begin : g_tone
         assign src[k] = DATA_W'(tone);
      end else if (k == STAT_OFS) begin : g_stat
         assign src[k] = status;
      end else begin : g_fill
         assign src[k] = FILL;
      end
   end

   assign rdata = src[off];

endmodule

// File: rtl/pbus_card_regs.sv
module pbus_card_regs
   import pbus_pkg::*;
#(
   parameter int              ADDR_W     = 10,
   parameter int              DATA_W     = 8,
   parameter int              OFF_W      = 3,
   parameter int              TONE_W     = 4,
   parameter int              SAMPLE_OFS = 0,
   parameter int              TONE_OFS   = 6,
   parameter int              STAT_OFS   = 7,
   parameter logic [DATA_W-1:0] FILL     = '1,
   parameter bit              EDGE_DET   = 1'b1,
   localparam int             NREG       = 1 << OFF_W,
   localparam int             SW_W       = ADDR_W - OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_aen_n,
   input  logic              bus_ior_n,
   input  logic              bus_iow_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [SW_W-1:0]   win_sw,
   output logic              card_sel_n,
   output logic [NREG-1:0]   rd_stb_n,
   output logic [NREG-1:0]   wr_stb_n,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_eoc,
   input  logic [TONE_W-1:0] dtmf_code,
   input  logic              dtmf_det,
   input  logic              line_hook,
   input  logic              line_ring,
   input  logic              line_voice,
   output logic [DATA_W-1:0] dac_data,
   output logic              off_hook,
   output logic              tape_on,
   output logic              mic_on
);

   if (DATA_W < ST_USED) begin : g_bad_data
      $error("pbus_card_regs: DATA_W too narrow for status byte");
   end
   if (SAMPLE_OFS >= NREG || TONE_OFS >= NREG || STAT_OFS >= NREG) begin : g_bad_ofs
      $error("pbus_card_regs: register offset outside window");
   end
   if (SAMPLE_OFS == TONE_OFS || SAMPLE_OFS == STAT_OFS || TONE_OFS == STAT_OFS) begin : g_dup_ofs
      $error("pbus_card_regs: register offsets must differ");
   end

   logic              ready;
   logic              smp_clr;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] rdata;
   logic [OFF_W-1:0]  off;
   ctl_t              ctl_q;

   assign off = bus_addr[OFF_W-1:0];

   pbus_win_decode #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .aen_n      (bus_aen_n),
      .ior_n      (bus_ior_n),
      .iow_n      (bus_iow_n),
      .win_sw     (win_sw),
      .card_sel_n (card_sel_n),
      .rd_stb_n   (rd_stb_n),
      .wr_stb_n   (wr_stb_n)
   );

   pbus_ctl_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_we (~wr_stb_n[STAT_OFS]),
      .dac_we (~wr_stb_n[SAMPLE_OFS]),
      .din    (bus_din),
      .ctl_q  (ctl_q),
      .dac_q  (dac_data)
   );

   assign smp_clr = ~rd_stb_n[SAMPLE_OFS] | ~wr_stb_n[SAMPLE_OFS];

   pbus_ready_flag #(
      .EDGE_DET (EDGE_DET)
   ) u_rdy (
      .clk   (clk),
      .rst_n (rst_n),
      .eoc   (adc_eoc),
      .clr   (smp_clr),
      .ready (ready)
   );

   always_comb begin
      status           = '0;
      status[ST_HOOK]  = line_hook;
      status[ST_RING]  = line_ring;
      status[ST_VOICE] = line_voice;
      status[ST_TONE]  = dtmf_det;
      status[ST_READY] = ready;
   end

   pbus_rd_mux #(
      .DATA_W     (DATA_W),
      .OFF_W      (OFF_W),
      .TONE_W     (TONE_W),
      .SAMPLE_OFS (SAMPLE_OFS),
      .TONE_OFS   (TONE_OFS),
      .STAT_OFS   (STAT_OFS),
      .FILL       (FILL)
   ) u_mux (
      .off    (off),
      .sample (adc_data),
      .tone   (dtmf_code),
      .status (status),
      .rdata  (rdata)
   );

   assign bus_doe  = ~card_sel_n & ~bus_ior_n;
   assign bus_dout = bus_doe ? rdata : '0;

   assign off_hook = ctl_q.off_hook;
   assign tape_on  = ctl_q.tape_on;
   assign mic_on   = ctl_q.mic_on;

   // R3: buffer drives only when some read strobe is active
   p_doe_has_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (rd_stb_n != '1));

   // R5: unused status bits read as zero
   p_stat_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_n[STAT_OFS] |-> (bus_dout[DATA_W-1:ST_USED] == '0));

   // R4: tone read drives zeros above the digit
   p_tone_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_n[TONE_OFS] |-> (bus_dout[DATA_W-1:TONE_W] == '0));

   // R8: writes outside the two writable offsets leave state alone
   p_unused_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_n[STAT_OFS] && wr_stb_n[SAMPLE_OFS])
         |=> ($stable(ctl_q) && $stable(dac_data)));

endmodule

// File: tb/pbus_card_regs_test.sv
module pbus_card_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] bus_addr = '0;
   logic       bus_aen_n = 1'b1;
   logic       bus_ior_n = 1'b1;
   logic       bus_iow_n = 1'b1;
   logic [7:0] bus_din = '0;
   logic [7:0] bus_dout;
   logic       bus_doe;
   logic [7:0] win_sw = 8'h4F;
   logic       card_sel_n;
   logic [7:0] rd_stb_n;
   logic [7:0] wr_stb_n;
   logic [7:0] adc_data = '0;
   logic       adc_eoc = 1'b0;
   logic [3:0] dtmf_code = '0;
   logic       dtmf_det = 1'b0;
   logic       line_hook = 1'b0;
   logic       line_ring = 1'b0;
   logic       line_voice = 1'b0;
   logic [7:0] dac_data;
   logic       off_hook;
   logic       tape_on;
   logic       mic_on;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pbus_card_regs uut (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_aen_n (bus_aen_n),
      .bus_ior_n (bus_ior_n), .bus_iow_n (bus_iow_n),
      .bus_din (bus_din), .bus_dout (bus_dout), .bus_doe (bus_doe),
      .win_sw (win_sw), .card_sel_n (card_sel_n),
      .rd_stb_n (rd_stb_n), .wr_stb_n (wr_stb_n),
      .adc_data (adc_data), .adc_eoc (adc_eoc),
      .dtmf_code (dtmf_code), .dtmf_det (dtmf_det),
      .line_hook (line_hook), .line_ring (line_ring), .line_voice (line_voice),
      .dac_data (dac_data), .off_hook (off_hook),
      .tape_on (tape_on), .mic_on (mic_on)
   );

   // {addr, aen_n, ior_n, iow_n, sw, exp_sel_n, exp_rd_stb_n, exp_wr_stb_n}
   localparam int NV = 10;
   localparam logic [37:0] VEC [NV] = '{
      {10'h278, 1'b0, 1'b0, 1'b1, 8'h4F, 1'b0, 8'hFE, 8'hFF},
      {10'h27F, 1'b0, 1'b0, 1'b1, 8'h4F, 1'b0, 8'h7F, 8'hFF},
      {10'h27B, 1'b0, 1'b1, 1'b0, 8'h4F, 1'b0, 8'hFF, 8'hF7},
      {10'h278, 1'b1, 1'b0, 1'b1, 8'h4F, 1'b1, 8'hFF, 8'hFF},
      {10'h278, 1'b0, 1'b1, 1'b1, 8'h4F, 1'b1, 8'hFF, 8'hFF},
      {10'h280, 1'b0, 1'b0, 1'b1, 8'h4F, 1'b1, 8'hFF, 8'hFF},
      {10'h078, 1'b0, 1'b0, 1'b1, 8'h4F, 1'b1, 8'hFF, 8'hFF},
      {10'h3FD, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b0, 8'hDF, 8'hFF},
      {10'h27D, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1, 8'hFF, 8'hFF},
      {10'h27E, 1'b0, 1'b1, 1'b0, 8'h4F, 1'b0, 8'hFF, 8'hBF}
   };

   logic       e_sel;
   logic [7:0] e_rd;
   logic [7:0] e_wr;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      bus_ior_n = 1'b1;
      bus_iow_n = 1'b1;
      bus_aen_n = 1'b0;
   endtask

   task automatic bus_wr(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_din = d; bus_aen_n = 1'b0; bus_iow_n = 1'b0;
      @(negedge clk);
      idle();
   endtask

   task automatic bus_rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_aen_n = 1'b0; bus_ior_n = 1'b0;
      #1;
      chk(tag, {8'h00, bus_dout}, {8'h00, exp});
      chk({tag, " doe"}, {15'h0, bus_doe}, 16'h1);
      @(negedge clk);
      idle();
   endtask

   task automatic eoc_pulse();
      @(negedge clk);
      adc_eoc = 1'b1;
      @(negedge clk);
      adc_eoc = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk("R12 ctrl at reset", {13'h0, mic_on, tape_on, off_hook}, 16'h0);
      chk("R12 dac at reset", {8'h0, dac_data}, 16'h0);
      rst_n = 1'b1;
      idle();
      bus_rd(10'h27F, 8'h00, "R12 status after reset");

      // R1 R2 R3: decode vectors
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {bus_addr, bus_aen_n, bus_ior_n, bus_iow_n, win_sw, e_sel, e_rd, e_wr} = VEC[i];
         #1;
         chk($sformatf("R1 sel vec%0d", i), {15'h0, card_sel_n}, {15'h0, e_sel});
         chk($sformatf("R2 rd strobes vec%0d", i), {8'h0, rd_stb_n}, {8'h0, e_rd});
         chk($sformatf("R2 wr strobes vec%0d", i), {8'h0, wr_stb_n}, {8'h0, e_wr});
         chk($sformatf("R3 doe vec%0d", i), {15'h0, bus_doe},
             {15'h0, ~e_sel & ~bus_ior_n});
         if (bus_doe !== 1'b1)
            chk($sformatf("R3 dout idle vec%0d", i), {8'h0, bus_dout}, 16'h0);
      end
      @(negedge clk);
      win_sw = 8'h4F;
      idle();

      // R4: read map
      adc_data = 8'hA5;
      dtmf_code = 4'h9;
      bus_rd(10'h278, 8'hA5, "R4 sample read");
      bus_rd(10'h27E, 8'h09, "R4 tone read");
      bus_rd(10'h27B, 8'hFF, "R4 unused read 3");
      bus_rd(10'h279, 8'hFF, "R4 unused read 1");

      // R5: status layout
      line_hook = 1'b1; line_ring = 1'b0; line_voice = 1'b1; dtmf_det = 1'b1;
      bus_rd(10'h27F, 8'h0D, "R5 status pattern a");
      line_hook = 1'b0; line_ring = 1'b1; line_voice = 1'b0; dtmf_det = 1'b0;
      bus_rd(10'h27F, 8'h02, "R5 status pattern b");
      line_ring = 1'b0;

      // R6 R7: writes
      bus_wr(10'h27F, 8'hFF);
      chk("R6 ctrl all set", {13'h0, mic_on, tape_on, off_hook}, 16'h7);
      bus_rd(10'h27F, 8'h00, "R6 status unaffected by ctrl");
      bus_wr(10'h278, 8'h3C);
      chk("R7 dac load", {8'h0, dac_data}, 16'h3C);

      // R8: ignored writes
      bus_wr(10'h27B, 8'h00);
      chk("R8 ctrl after write 3", {13'h0, mic_on, tape_on, off_hook}, 16'h7);
      chk("R8 dac after write 3", {8'h0, dac_data}, 16'h3C);
      bus_wr(10'h27E, 8'h00);
      chk("R8 ctrl after write 6", {13'h0, mic_on, tape_on, off_hook}, 16'h7);
      chk("R8 dac after write 6", {8'h0, dac_data}, 16'h3C);
      bus_wr(10'h27F, 8'hFA);
      chk("R6 ctrl upper bits dropped", {13'h0, mic_on, tape_on, off_hook}, 16'h2);

      // R9 R10: ready flag
      eoc_pulse();
      bus_rd(10'h27F, 8'h10, "R9 ready set by eoc");
      bus_rd(10'h27F, 8'h10, "R10 status read keeps ready");
      bus_rd(10'h278, 8'hA5, "R10 sample read");
      bus_rd(10'h27F, 8'h00, "R10 cleared by read");
      eoc_pulse();
      bus_wr(10'h278, 8'h11);
      bus_rd(10'h27F, 8'h00, "R10 cleared by write");

      // R9: held level sets once
      @(negedge clk);
      adc_eoc = 1'b1;
      bus_rd(10'h278, 8'hA5, "R9 read while eoc held");
      bus_rd(10'h27F, 8'h00, "R9 held eoc no re-set");
      @(negedge clk);
      adc_eoc = 1'b0;

      // R11: set beats clear
      @(negedge clk);
      bus_addr = 10'h278; bus_aen_n = 1'b0; bus_ior_n = 1'b0; adc_eoc = 1'b1;
      @(negedge clk);
      idle(); adc_eoc = 1'b0;
      bus_rd(10'h27F, 8'h10, "R11 set wins over clear");

      // R12: reset mid-run
      bus_wr(10'h27F, 8'h07);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 ctrl mid reset", {13'h0, mic_on, tape_on, off_hook}, 16'h0);
      chk("R12 dac mid reset", {8'h0, dac_data}, 16'h0);
      rst_n = 1'b1;
      bus_rd(10'h27F, 8'h00, "R12 ready mid reset");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule